// File: doc/BRIEF.md
# Programming Mode Entry Controller

This block decides when an embedded target switches into external programming mode and when it returns to normal operation. It watches the raw reset pin, a pin that selects which reset level counts as active, a power-on-reset completion signal from the supply monitor, and a fuse bit that enables programming entry. While its programming-mode output is high, the core is held in reset and the serial pins belong to the programming interface.

With the fuse set, any reset period opens a programming session, and the session closes when reset goes inactive. With the fuse cleared, a session can only start if reset is already active when power-on reset completes. Such a session lasts until reset goes inactive. After that, a session-used latch is set, and no further session is possible until the power-on-reset signal is asserted again, which stands for a power cycle. The reset and polarity pins pass through a synchroniser before any decision is made.

Top module: `pgm_entry_ctrl`

## Requirements
- R1: The polarity pin selects the active reset level. With polarity 1 the reset pin is active when high. With polarity 0 it is active when low, so a pin tied low forces reset active.
- R2: With the fuse set and power-on reset complete, programming mode rises on the third rising clock edge after the reset pin becomes active. It is still low after the second edge.
- R3: With the fuse set, programming mode falls on the third rising edge after the reset pin becomes inactive. A later reset period opens a new session.
- R4: With the fuse cleared, a reset period that begins after power-on reset has completed never raises programming mode.
- R5: With the fuse cleared and reset already active when the power-on-reset-done signal rises, programming mode rises on the first rising edge after that. It stays high for as long as reset stays active.
- R6: When a session opened by R5 ends, programming mode falls on the third rising edge after reset becomes inactive, and the session-used output goes high on that same edge. Later reset periods do not raise programming mode.
- R7: A low power-on-reset-done input clears programming mode and session-used at once, without waiting for a clock edge.
- R8: With the fuse set, a session that starts at power-on-reset completion leaves session-used low when it ends, and later reset periods still open sessions.
- R9: Programming mode stays low while power-on-reset-done is low, whatever the reset pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_pin_i | input | 1 | Raw reset pin, asynchronous |
| rst_pol_i | input | 1 | Reset polarity select, 1 = active high, 0 = active low |
| por_done_i | input | 1 | Power-on reset complete; low clears the controller asynchronously |
| isp_fuse_i | input | 1 | Programming-enable fuse, 1 = entry allowed in any reset period |
| prog_mode_o | output | 1 | Programming mode: holds the core in reset and hands over the serial pins |
| session_used_o | output | 1 | A one-shot session from the power-on-reset window has been consumed |

## Verification
A change on the reset pin passes two synchroniser flops and then the state register, so programming mode responds on the third rising edge. Session-used changes on that same edge. The rising edge of power-on-reset-done acts on the state register directly and takes effect after one edge. Lowering it clears the state at once. The bench drives every input at a falling edge, steps a counted number of rising edges, and samples at the next falling edge. For each pin change it samples once at the edge just before the output is due and once at the edge where it is due, so an early or late output is caught in both directions.

// File: rtl/pme_pkg.sv
package pme_pkg;

    typedef enum logic [2:0] {
        ST_POR       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_PROG_ANY  = 3'd2,
        ST_PROG_ONCE = 3'd3,
        ST_LOCKED    = 3'd4
    } pme_state_e;

    typedef struct packed {
        pme_state_e state;
        logic       used;
    } pme_regs_t;

    localparam pme_regs_t PME_REGS_RESET = '{state: ST_POR, used: 1'b0};

endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = din_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            always_comb begin
                stage_d[g] = stage_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        stage_q <= stage_d;
    end

    assign dout_o = stage_q[LAST];

endmodule

// File: rtl/pme_fsm.sv
module pme_fsm
    import pme_pkg::*;
(
    input  logic clk_i,
    input  logic por_done_i,
    input  logic rst_act_i,
    input  logic fuse_en_i,
    output logic prog_mode_o,
    output logic session_used_o
);
    pme_regs_t r_d;
    pme_regs_t r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_POR: begin
                // first edge after the power-on window closes
                if (rst_act_i) begin
                    r_d.state = fuse_en_i ? ST_PROG_ANY : ST_PROG_ONCE;
                end else begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (rst_act_i && fuse_en_i) begin
                    r_d.state = ST_PROG_ANY;
                end
            end
            ST_PROG_ANY: begin
                if (!rst_act_i) begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_PROG_ONCE: begin
                if (!rst_act_i) begin
                    r_d.state = ST_LOCKED;
                    r_d.used  = 1'b1;
                end
            end
            ST_LOCKED: begin
                r_d.state = ST_LOCKED;
            end
            default: begin
                r_d = PME_REGS_RESET;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge por_done_i) begin
        if (!por_done_i) begin
            r_q <= PME_REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_mode_o    = (r_q.state == ST_PROG_ANY) || (r_q.state == ST_PROG_ONCE);
    assign session_used_o = r_q.used;

    // R2 / R5: entry only with reset active
    a_r2_entry_needs_reset: assert property (@(posedge clk_i) disable iff (!por_done_i)
        $rose(prog_mode_o) |-> $past(rst_act_i));

    // R3 / R6: inactive reset closes a session on the next edge
    a_r3_exit_on_release: assert property (@(posedge clk_i) disable iff (!por_done_i)
        (prog_mode_o && !rst_act_i) |=> !prog_mode_o);

    // R4: with the fuse cleared, entry only from the power-on window
    a_r4_fuse_off_por_only: assert property (@(posedge clk_i) disable iff (!por_done_i)
        ($rose(prog_mode_o) && !$past(fuse_en_i)) |-> ($past(r_q.state) == ST_POR));

    // R6: a consumed session blocks further entry
    a_r6_locked_no_entry: assert property (@(posedge clk_i) disable iff (!por_done_i)
        session_used_o |=> !prog_mode_o);

    // R6: the latch sets only as a session closes
    a_r6_used_on_exit: assert property (@(posedge clk_i) disable iff (!por_done_i)
        $rose(session_used_o) |-> ($past(prog_mode_o) && !prog_mode_o));

    // R8: fuse-enabled sessions never consume the latch
    a_r8_fuse_keeps_latch: assert property (@(posedge clk_i) disable iff (!por_done_i)
        (prog_mode_o && $past(fuse_en_i) && (r_q.state == ST_PROG_ANY)) |=> !$rose(session_used_o));

endmodule

// File: rtl/pgm_entry_ctrl.sv
module pgm_entry_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_pin_i,
    input  logic rst_pol_i,
    input  logic por_done_i,
    input  logic isp_fuse_i,
    output logic prog_mode_o,
    output logic session_used_o
);
    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] raw_pins;
    logic [SYNC_W-1:0] sync_pins;
    logic              rst_act;

    assign raw_pins = {rst_pol_i, rst_pin_i};

    pme_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i  (clk_i),
        .din_i  (raw_pins),
        .dout_o (sync_pins)
    );

    // R1: polarity 1 = active high, 0 = active low
    assign rst_act = sync_pins[1] ? sync_pins[0] : ~sync_pins[0];

    pme_fsm fsm_i (
        .clk_i          (clk_i),
        .por_done_i     (por_done_i),
        .rst_act_i      (rst_act),
        .fuse_en_i      (isp_fuse_i),
        .prog_mode_o    (prog_mode_o),
        .session_used_o (session_used_o)
    );

    // R9: no programming mode during the power-on window
    a_r9_quiet_in_por: assert property (@(posedge clk_i) disable iff (por_done_i)
        !por_done_i |-> !prog_mode_o);

endmodule

// File: tb/pgm_entry_ctrl_tb_top.sv
module pgm_entry_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_pin = 1'b0;
    logic rst_pol = 1'b1;
    logic por_done = 1'b0;
    logic fuse = 1'b0;
    logic prog_mode;
    logic session_used;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pgm_entry_ctrl dut_i (
        .clk_i          (clk),
        .rst_pin_i      (rst_pin),
        .rst_pol_i      (rst_pol),
        .por_done_i     (por_done),
        .isp_fuse_i     (fuse),
        .prog_mode_o    (prog_mode),
        .session_used_o (session_used)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // hold POR, set inputs, flush synchroniser, release
    task automatic power_up(input logic f, input logic pol, input logic pin);
        por_done = 1'b0;
        fuse = f;
        rst_pol = pol;
        rst_pin = pin;
        step(4);
        chk("R9 prog low in POR", prog_mode, 1'b0);
        chk("R7 used low in POR", session_used, 1'b0);
        por_done = 1'b1;
    endtask

    task automatic t_fuse_sessions;
        power_up(1'b1, 1'b1, 1'b0);
        step(4);
        chk("R2 idle after POR", prog_mode, 1'b0);
        rst_pin = 1'b1;
        step(2);
        chk("R2 not yet at edge 2", prog_mode, 1'b0);
        step(1);
        chk("R2 entry at edge 3", prog_mode, 1'b1);
        rst_pin = 1'b0;
        step(2);
        chk("R3 still in at edge 2", prog_mode, 1'b1);
        step(1);
        chk("R3 exit at edge 3", prog_mode, 1'b0);
        rst_pin = 1'b1;
        step(3);
        chk("R3 second session", prog_mode, 1'b1);
        rst_pin = 1'b0;
        step(3);
        chk("R3 second exit", prog_mode, 1'b0);
        chk("R8 used stays low", session_used, 1'b0);
    endtask

    task automatic t_pol_low;
        power_up(1'b1, 1'b0, 1'b1);
        step(4);
        chk("R1 high pin inactive when pol=0", prog_mode, 1'b0);
        rst_pin = 1'b0;
        step(3);
        chk("R1 low pin active when pol=0", prog_mode, 1'b1);
        rst_pin = 1'b1;
        step(3);
        chk("R1 release when pol=0", prog_mode, 1'b0);
    endtask

    task automatic t_fuse_off_late;
        power_up(1'b0, 1'b1, 1'b0);
        step(3);
        rst_pin = 1'b1;
        step(6);
        chk("R4 late reset ignored", prog_mode, 1'b0);
        rst_pin = 1'b0;
        step(4);
        chk("R4 used untouched", session_used, 1'b0);
    endtask

    task automatic t_por_window;
        power_up(1'b0, 1'b0, 1'b0);
        step(1);
        chk("R5 entry one edge after POR", prog_mode, 1'b1);
        step(10);
        chk("R5 held while reset active", prog_mode, 1'b1);
        chk("R6 used low during session", session_used, 1'b0);
        rst_pin = 1'b1;
        step(2);
        chk("R6 still in at edge 2", prog_mode, 1'b1);
        step(1);
        chk("R6 exit at edge 3", prog_mode, 1'b0);
        chk("R6 used set on exit", session_used, 1'b1);
        rst_pin = 1'b0;
        step(6);
        chk("R6 no second session", prog_mode, 1'b0);
        chk("R6 used held", session_used, 1'b1);
        // power cycle clears immediately
        @(negedge clk);
        por_done = 1'b0;
        #1;
        chk("R7 used cleared at once", session_used, 1'b0);
        chk("R7 prog cleared at once", prog_mode, 1'b0);
        step(1);
    endtask

    task automatic t_por_clears_active;
        power_up(1'b0, 1'b1, 1'b1);
        step(1);
        chk("R5 entry active-high", prog_mode, 1'b1);
        por_done = 1'b0;
        #1;
        chk("R7 session aborted by POR", prog_mode, 1'b0);
        step(3);
        chk("R9 reset active, POR low", prog_mode, 1'b0);
    endtask

    task automatic t_fuse_por_entry;
        power_up(1'b1, 1'b1, 1'b1);
        step(1);
        chk("R8 entry at POR with fuse", prog_mode, 1'b1);
        rst_pin = 1'b0;
        step(3);
        chk("R8 exit", prog_mode, 1'b0);
        chk("R8 used stays low", session_used, 1'b0);
        rst_pin = 1'b1;
        step(3);
        chk("R8 later session allowed", prog_mode, 1'b1);
        rst_pin = 1'b0;
        step(3);
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_fuse_sessions();
        t_pol_low();
        t_fuse_off_late();
        t_por_window();
        t_por_clears_active();
        t_fuse_por_entry();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule